// File: doc/BRIEF.md
# Legacy Divisor Port Fallback Controller

This block is the register-bank front end of a UART. It holds the line control register, two extended control registers, the modem control register and the 16-bit baud divisor. It steers each bus access to the right one of these according to the bank chosen in the line control register. The serial data path and FIFOs sit outside. Offsets 0 and 1 are reached only as strobes toward them, plus a receive byte input that is returned on reads.

When the legacy bank is selected, offsets 0 and 1 are the divisor's low and high bytes. Touching either one by read or by write is a mode-change event. It drops the UART back to the non-extended mode and clears a set of control bits. Which bits are cleared depends on the mode in force and on a lock bit. Non-extended mode with the lock set turns the access into a no-op. The extended bank holds a second pair of divisor ports, which update the same divisor silently.

Top module: `ldp_fallback_ctrl`

## Requirements
- R1: After synchronous reset, the divisor, line control, both extended control registers, the modem control register, the read data and every strobe, mode and fallback output are zero.
- R2: The line control register sits at offset 3 in every bank, and its bits 7:6 pick the bank. 0x selects the data bank: offsets 0/1 pulse the data strobes, reads there return `rx_data_i`, control register 1 is at offset 2 and the modem control register at offset 5. 10 selects the legacy bank. 11 selects the extended bank: alternate divisor ports at 0/1, control register 1 at 2, control register 2 at 4, modem control at 5.
- R3: Divisor byte order is offset 0 for the low byte and offset 1 for the high byte. Reads of either divisor port pair return the matching byte.
- R4: In the legacy bank, offsets 2 and 4 to 7 read as zero, and writes to them change nothing.
- R5: If extended mode is set (control register 1 bit 0), a legacy divisor read or write asserts a fallback pulse. It also clears control register 1 bits 0, 5 and 7, control register 2 bits 0 to 5 and modem control bits 2 to 7, whatever the lock bit (control register 1 bit 7). A write also stores the byte.
- R6: In non-extended mode with the lock clear, a legacy divisor access asserts the fallback pulse and clears control register 1 bits 5 and 7 and control register 2 bits 0 to 5. The modem control register is left unchanged, and a write stores the byte.
- R7: In non-extended mode with the lock set, a legacy divisor access gives no fallback pulse, leaves the divisor unchanged and clears nothing.
- R8: Writes to the alternate divisor ports in the extended bank update the divisor without any fallback pulse or register clearing.
- R9: Register updates and the one-cycle fallback pulse appear in the cycle after the clock edge that samples the access. Read data is registered on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| rx_data_i | input | 8 | Byte returned by data-bank reads |
| bus_rdata | output | 8 | Registered read data |
| data_wr_o | output | 1 | Data-bank write pulse |
| data_rd_o | output | 1 | Data-bank read pulse |
| data_sel_o | output | 1 | Data-bank offset (0 or 1) of the last data access |
| divisor_o | output | 16 | Baud divisor |
| lcr_o | output | 8 | Line control register |
| ecr1_o | output | 8 | Extended control register 1 (bit 0 mode, bit 7 lock) |
| ecr2_o | output | 8 | Extended control register 2 |
| mcr_o | output | 8 | Modem control register |
| ext_mode_o | output | 1 | Extended mode flag |
| fallback_o | output | 1 | One-cycle fallback pulse |

## Verification
The hardest state to reach is the third fallback case: non-extended mode with the lock bit set. Control register 1 cannot be written from the legacy bank, so the stimulus has to leave that bank, write the lock, switch back through the line control register and then touch the divisor. The same detour is needed for the extended-mode-plus-lock case. That case must still fall back and clear the lock itself, which then unlocks the next access. The vector table walks these bank round trips in sequence, and it checks the divisor and control registers with idle cycles after each access.

// File: rtl/ldp_pkg.sv
package ldp_pkg;
  localparam int DW = 8;

  typedef enum logic [1:0] {
    BANK_DATA   = 2'd0,
    BANK_LEGACY = 2'd1,
    BANK_EXT    = 2'd2
  } bank_e;

  localparam int EXT_BIT  = 0;
  localparam int LOCK_BIT = 7;

  localparam logic [DW-1:0] ECR1_CLR_EXT = 8'hA1;
  localparam logic [DW-1:0] ECR1_CLR_STD = 8'hA0;
  localparam logic [DW-1:0] ECR2_CLR     = 8'h3F;
  localparam logic [DW-1:0] MCR_CLR_EXT  = 8'hFC;

  localparam logic [2:0] OFS_LCR  = 3'd3;
  localparam logic [2:0] OFS_ECR1 = 3'd2;
  localparam logic [2:0] OFS_ECR2 = 3'd4;
  localparam logic [2:0] OFS_MCR  = 3'd5;
endpackage

// File: rtl/ldp_bank_decode.sv
module ldp_bank_decode
  import ldp_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    bank_bits,
  output bank_e         bank,
  output logic          data_hit,
  output logic          leg_div_hit,
  output logic          alt_div_hit,
  output logic          lcr_hit,
  output logic          ecr1_hit,
  output logic          ecr2_hit,
  output logic          mcr_hit
);
  logic low_pair;

  always_comb begin
    if (!bank_bits[1])     bank = BANK_DATA;
    else if (!bank_bits[0]) bank = BANK_LEGACY;
    else                    bank = BANK_EXT;

    low_pair    = (addr[AW-1:1] == '0);
    data_hit    = low_pair && (bank == BANK_DATA);
    leg_div_hit = low_pair && (bank == BANK_LEGACY);
    alt_div_hit = low_pair && (bank == BANK_EXT);
    lcr_hit     = (addr == AW'(OFS_LCR));
    ecr1_hit    = (addr == AW'(OFS_ECR1)) && (bank != BANK_LEGACY);
    ecr2_hit    = (addr == AW'(OFS_ECR2)) && (bank == BANK_EXT);
    mcr_hit     = (addr == AW'(OFS_MCR))  && (bank != BANK_LEGACY);
  end
endmodule

// File: rtl/ldp_ctrl_regs.sv
module ldp_ctrl_regs
  import ldp_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         lcr_hit,
  input  logic         ecr1_hit,
  input  logic         ecr2_hit,
  input  logic         mcr_hit,
  input  logic         fb_evt,
  output logic [W-1:0] lcr,
  output logic [W-1:0] ecr1,
  output logic [W-1:0] ecr2,
  output logic [W-1:0] mcr
);
  logic          ext_now;
  logic [W-1:0]  ecr1_mask;
  logic [W-1:0]  mcr_mask;

  always_comb begin
    ext_now   = ecr1[EXT_BIT];
    ecr1_mask = ext_now ? W'(ECR1_CLR_EXT) : W'(ECR1_CLR_STD);
    mcr_mask  = ext_now ? W'(MCR_CLR_EXT)  : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lcr  <= '0;
      ecr1 <= '0;
      ecr2 <= '0;
      mcr  <= '0;
    end else if (fb_evt) begin
      ecr1 <= ecr1 & ~ecr1_mask;
      ecr2 <= ecr2 & ~W'(ECR2_CLR);
      mcr  <= mcr  & ~mcr_mask;
    end else if (wr) begin
      if (lcr_hit)  lcr  <= wdata;
      if (ecr1_hit) ecr1 <= wdata;
      if (ecr2_hit) ecr2 <= wdata;
      if (mcr_hit)  mcr  <= wdata;
    end
  end
endmodule

// File: rtl/ldp_divisor.sv
module ldp_divisor #(
  parameter int W = 8,
  parameter int BYTES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [$clog2(BYTES)-1:0] sel,
  input  logic [W-1:0]          wdata,
  output logic [W*BYTES-1:0]    div
);
  for (genvar g = 0; g < BYTES; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)
        div[g*W +: W] <= '0;
      else if (we && (sel == g))
        div[g*W +: W] <= wdata;
    end
  end
endmodule

// File: rtl/ldp_fallback_ctrl.sv
module ldp_fallback_ctrl
  import ldp_pkg::*;
#(
  parameter int AW = 3,
  parameter int W  = DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [W-1:0]  bus_wdata,
  input  logic [W-1:0]  rx_data_i,
  output logic [W-1:0]  bus_rdata,
  output logic          data_wr_o,
  output logic          data_rd_o,
  output logic          data_sel_o,
  output logic [2*W-1:0] divisor_o,
  output logic [W-1:0]  lcr_o,
  output logic [W-1:0]  ecr1_o,
  output logic [W-1:0]  ecr2_o,
  output logic [W-1:0]  mcr_o,
  output logic          ext_mode_o,
  output logic          fallback_o
);
  bank_e bank;
  logic data_hit, leg_div_hit, alt_div_hit;
  logic lcr_hit, ecr1_hit, ecr2_hit, mcr_hit;
  logic access, locked_std, fb_evt, div_we;
  logic [W-1:0] rd_next;

  ldp_bank_decode #(.AW(AW)) u_dec (
    .addr(bus_addr), .bank_bits(lcr_o[W-1 -: 2]), .bank(bank),
    .data_hit(data_hit), .leg_div_hit(leg_div_hit), .alt_div_hit(alt_div_hit),
    .lcr_hit(lcr_hit), .ecr1_hit(ecr1_hit), .ecr2_hit(ecr2_hit), .mcr_hit(mcr_hit)
  );

  always_comb begin
    access     = bus_wr || bus_rd;
    locked_std = !ecr1_o[EXT_BIT] && ecr1_o[LOCK_BIT];
    fb_evt     = access && leg_div_hit && !locked_std;
    div_we     = bus_wr && (alt_div_hit || (leg_div_hit && !locked_std));
  end

  ldp_ctrl_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .wdata(bus_wdata),
    .lcr_hit(lcr_hit), .ecr1_hit(ecr1_hit), .ecr2_hit(ecr2_hit), .mcr_hit(mcr_hit),
    .fb_evt(fb_evt), .lcr(lcr_o), .ecr1(ecr1_o), .ecr2(ecr2_o), .mcr(mcr_o)
  );

  ldp_divisor #(.W(W), .BYTES(2)) u_div (
    .clk(clk), .rst(rst), .we(div_we), .sel(bus_addr[0]),
    .wdata(bus_wdata), .div(divisor_o)
  );

  always_comb begin
    rd_next = '0;
    if (data_hit)                         rd_next = rx_data_i;
    else if (leg_div_hit || alt_div_hit)  rd_next = divisor_o[bus_addr[0]*W +: W];
    else if (lcr_hit)                     rd_next = lcr_o;
    else if (ecr1_hit)                    rd_next = ecr1_o;
    else if (ecr2_hit)                    rd_next = ecr2_o;
    else if (mcr_hit)                     rd_next = mcr_o;
  end

  assign ext_mode_o = ecr1_o[EXT_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      data_wr_o  <= 1'b0;
      data_rd_o  <= 1'b0;
      data_sel_o <= 1'b0;
      fallback_o <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_next;
      data_wr_o  <= bus_wr && data_hit;
      data_rd_o  <= bus_rd && data_hit;
      if (access && data_hit) data_sel_o <= bus_addr[0];
      fallback_o <= fb_evt;
    end
  end
endmodule

// File: rtl/ldp_fallback_ctrl_chk.sv
module ldp_fallback_ctrl_chk #(
  parameter int AW = 3,
  parameter int W  = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [2*W-1:0] divisor_o,
  input logic [W-1:0]  lcr_o,
  input logic [W-1:0]  ecr1_o,
  input logic [W-1:0]  ecr2_o,
  input logic [W-1:0]  mcr_o,
  input logic          ext_mode_o,
  input logic          fallback_o
);
  logic pair, leg_acc, alt_wr;
  always_comb begin
    pair    = (bus_addr[AW-1:1] == '0);
    leg_acc = (bus_wr || bus_rd) && pair && (lcr_o[W-1 -: 2] == 2'b10);
    alt_wr  = bus_wr && pair && (lcr_o[W-1 -: 2] == 2'b11);
  end

  assert_fb_std_mode_R5: assert property (@(posedge clk) disable iff (rst)
    fallback_o |-> !ext_mode_o);
  assert_ext_mcr_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (fallback_o && $past(ext_mode_o)) |-> (mcr_o[W-1:2] == '0));
  assert_std_mcr_kept_R6: assert property (@(posedge clk) disable iff (rst)
    (fallback_o && !$past(ext_mode_o)) |-> (mcr_o == $past(mcr_o)));
  assert_ecr2_clear_R6: assert property (@(posedge clk) disable iff (rst)
    fallback_o |-> (ecr2_o[5:0] == '0));
  assert_lock_noop_R7: assert property (@(posedge clk) disable iff (rst)
    (leg_acc && !ext_mode_o && ecr1_o[W-1]) |=> (!fallback_o && $stable(divisor_o) && $stable(ecr1_o)));
  assert_alt_silent_R8: assert property (@(posedge clk) disable iff (rst)
    alt_wr |=> !fallback_o);
  assert_pulse_cause_R9: assert property (@(posedge clk) disable iff (rst)
    fallback_o |-> $past(leg_acc));
endmodule

bind ldp_fallback_ctrl ldp_fallback_ctrl_chk #(.AW(AW), .W(W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .divisor_o(divisor_o), .lcr_o(lcr_o), .ecr1_o(ecr1_o), .ecr2_o(ecr2_o),
  .mcr_o(mcr_o), .ext_mode_o(ext_mode_o), .fallback_o(fallback_o)
);

// File: tb/tb_ldp_fallback_ctrl.sv
module tb_ldp_fallback_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] rx_data_i = 8'hA5;
  logic [7:0] bus_rdata, lcr_o, ecr1_o, ecr2_o, mcr_o;
  logic data_wr_o, data_rd_o, data_sel_o, ext_mode_o, fallback_o;
  logic [15:0] divisor_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ldp_fallback_ctrl dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .rx_data_i(rx_data_i), .bus_rdata(bus_rdata),
    .data_wr_o(data_wr_o), .data_rd_o(data_rd_o), .data_sel_o(data_sel_o),
    .divisor_o(divisor_o), .lcr_o(lcr_o), .ecr1_o(ecr1_o), .ecr2_o(ecr2_o),
    .mcr_o(mcr_o), .ext_mode_o(ext_mode_o), .fallback_o(fallback_o)
  );

  // op: 0 idle, 1 write, 2 read. sel: 0 rdata,1 divisor,2 ecr1,3 ecr2,4 mcr,5 fallback,6 data_wr,7 lcr
  localparam int NV = 47;
  localparam logic [35:0] VEC [NV] = '{
    {2'd1,3'd3,8'hC0,3'd7,16'h00C0,4'd2},   // R2 extended bank
    {2'd1,3'd2,8'hFF,3'd2,16'h00FF,4'd2},   // R2
    {2'd1,3'd4,8'hFF,3'd3,16'h00FF,4'd2},   // R2
    {2'd1,3'd5,8'hFF,3'd4,16'h00FF,4'd2},   // R2
    {2'd1,3'd0,8'h34,3'd5,16'h0000,4'd8},   // R8 alt low, no pulse
    {2'd1,3'd1,8'h12,3'd1,16'h1234,4'd8},   // R8 alt high
    {2'd2,3'd0,8'h00,3'd0,16'h0034,4'd3},   // R3
    {2'd2,3'd1,8'h00,3'd0,16'h0012,4'd3},   // R3
    {2'd2,3'd2,8'h00,3'd0,16'h00FF,4'd8},   // R8 ecr1 untouched
    {2'd1,3'd3,8'h80,3'd7,16'h0080,4'd2},   // R2 legacy bank
    {2'd2,3'd0,8'h00,3'd5,16'h0001,4'd5},   // R5 read triggers fallback
    {2'd0,3'd0,8'h00,3'd5,16'h0000,4'd9},   // R9 pulse one cycle
    {2'd0,3'd0,8'h00,3'd2,16'h005E,4'd5},   // R5
    {2'd0,3'd0,8'h00,3'd3,16'h00C0,4'd5},   // R5
    {2'd0,3'd0,8'h00,3'd4,16'h0003,4'd5},   // R5
    {2'd1,3'd3,8'hC0,3'd7,16'h00C0,4'd2},
    {2'd1,3'd5,8'hFF,3'd4,16'h00FF,4'd2},
    {2'd1,3'd4,8'hFF,3'd3,16'h00FF,4'd2},
    {2'd1,3'd2,8'h7E,3'd2,16'h007E,4'd2},
    {2'd1,3'd3,8'h80,3'd7,16'h0080,4'd2},
    {2'd1,3'd0,8'h56,3'd5,16'h0001,4'd6},   // R6 unlocked std
    {2'd0,3'd0,8'h00,3'd1,16'h1256,4'd6},   // R6
    {2'd0,3'd0,8'h00,3'd2,16'h005E,4'd6},   // R6
    {2'd0,3'd0,8'h00,3'd3,16'h00C0,4'd6},   // R6
    {2'd0,3'd0,8'h00,3'd4,16'h00FF,4'd6},   // R6 mcr kept
    {2'd1,3'd3,8'hC0,3'd7,16'h00C0,4'd2},
    {2'd1,3'd2,8'h80,3'd2,16'h0080,4'd7},
    {2'd1,3'd3,8'h80,3'd7,16'h0080,4'd2},
    {2'd1,3'd1,8'h99,3'd5,16'h0000,4'd7},   // R7 locked
    {2'd0,3'd0,8'h00,3'd1,16'h1256,4'd7},   // R7
    {2'd0,3'd0,8'h00,3'd2,16'h0080,4'd7},   // R7
    {2'd2,3'd1,8'h00,3'd5,16'h0000,4'd7},   // R7 locked read
    {2'd2,3'd4,8'h00,3'd0,16'h0000,4'd4},   // R4
    {2'd2,3'd2,8'h00,3'd0,16'h0000,4'd4},   // R4
    {2'd1,3'd2,8'hFF,3'd2,16'h0080,4'd4},   // R4 write ignored
    {2'd1,3'd6,8'hFF,3'd5,16'h0000,4'd4},   // R4
    {2'd1,3'd3,8'h00,3'd7,16'h0000,4'd2},   // R2 data bank
    {2'd1,3'd0,8'h77,3'd6,16'h0001,4'd2},   // R2 data strobe
    {2'd0,3'd0,8'h00,3'd1,16'h1256,4'd2},   // R2 divisor untouched
    {2'd2,3'd0,8'h00,3'd0,16'h00A5,4'd2},   // R2 rx data
    {2'd1,3'd3,8'hC0,3'd7,16'h00C0,4'd2},
    {2'd1,3'd2,8'h81,3'd2,16'h0081,4'd5},
    {2'd1,3'd3,8'h80,3'd7,16'h0080,4'd2},
    {2'd1,3'd1,8'h42,3'd5,16'h0001,4'd5},   // R5 lock ignored in ext
    {2'd0,3'd0,8'h00,3'd1,16'h4256,4'd5},   // R5
    {2'd0,3'd0,8'h00,3'd2,16'h0000,4'd5},   // R5
    {2'd2,3'd0,8'h00,3'd0,16'h0056,4'd3}    // R3
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h want %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pick(input logic [2:0] sel);
    case (sel)
      3'd0: pick = {8'h00, bus_rdata};
      3'd1: pick = divisor_o;
      3'd2: pick = {8'h00, ecr1_o};
      3'd3: pick = {8'h00, ecr2_o};
      3'd4: pick = {8'h00, mcr_o};
      3'd5: pick = {15'd0, fallback_o};
      3'd6: pick = {15'd0, data_wr_o};
      default: pick = {8'h00, lcr_o};
    endcase
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1 reset state
    check("R1", divisor_o, 16'h0);
    check("R1", {ecr1_o, ecr2_o}, 16'h0);
    check("R1", {mcr_o, lcr_o}, 16'h0);
    check("R1", {12'd0, fallback_o, data_wr_o, data_rd_o, ext_mode_o}, 16'h0);
    for (int i = 0; i < NV; i++) begin
      logic [35:0] v;
      v = VEC[i];
      bus_wr = (v[35:34] == 2'd1);
      bus_rd = (v[35:34] == 2'd2);
      bus_addr = v[33:31];
      bus_wdata = v[30:23];
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
      check($sformatf("R%0d vec %0d", v[3:0], i), pick(v[22:20]), v[19:4]);
    end
    // R1 reset mid-run
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    check("R1", divisor_o, 16'h0);
    check("R1", {ecr1_o, lcr_o}, 16'h0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (5000) @(posedge clk); n_chk++; n_bad++; $display("FAIL watchdog: got hang want done"); end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule